// File: doc/BRIEF.md
# Strobed Handshake Input Port

This block is an 8-bit peripheral input port that takes bytes from an external producer, such as a keyboard encoder, through a strobe handshake. The producer places a byte on the port pins and pulses an active-low strobe. When the strobe returns high, the port latches the byte and raises a buffer-full flag. It also raises an interrupt request if the interrupt-enable bit is set and the strobe line is high again. The strobe is asynchronous to the system clock, so it passes through a synchroniser and an edge detector before it is used.

The CPU side is a synchronous register interface with a one-bit address, a read strobe, a write strobe and byte-wide data. Address 0 reads the latched byte, and that read empties the buffer. Address 1 reads a status and control image. A write to address 1 with bit 7 clear sets or clears one bit of an 8-bit control register. The interrupt enable is one bit of that register, and its two top bits drive two spare general-purpose output pins.

Top module: `strobed_input_port`

## Requirements
- R1: During and after a synchronous reset, buf_full, irq, gpio_out, cpu_rdata and every control bit (including interrupt enable) are 0.
- R2: A low-to-high transition on pin_stb_n latches pin_data into the data register, and buf_full is set. Both are visible after the third rising clock edge that follows the transition. The data register does not change at any other time.
- R3: buf_full stays set until the CPU reads address 0.
- R4: irq is 1 exactly when buf_full is 1, interrupt enable (control bit 4) is 1, and the synchronised strobe is high. If the strobe goes low while the buffer is full, irq drops within three clock edges.
- R5: A read at address 0 returns the latched byte on cpu_rdata after the same clock edge. On that edge buf_full and irq both clear. If a new strobe edge is captured on the same edge, the capture wins and buf_full stays set.
- R6: A write at address 1 with wdata[7]=0 writes wdata[0] into the one control bit selected by wdata[3:1] and leaves the other control bits unchanged.
- R7: gpio_out[1:0] follows control bits 7:6, and gpio_in[1:0] is readable at status bits 7:6.
- R8: A strobe edge that arrives while buf_full is set overwrites the latched byte and leaves buf_full set.
- R9: Writes at address 0 and writes at address 1 with wdata[7]=1 change no control bit, no gpio_out pin and no flag.
- R10: A read at address 1 returns {gpio_in[1:0], buf_full, ctl[4], irq, ctl[2:0]} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_addr | input | 1 | Register select: 0 data, 1 status/control |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered CPU read data |
| pin_data | input | 8 | Peripheral data pins |
| pin_stb_n | input | 1 | Active-low peripheral strobe, asynchronous |
| gpio_in | input | 2 | Spare control-port pins, input side |
| gpio_out | output | 2 | Spare control-port pins, output side |
| buf_full | output | 1 | Latched byte not yet taken by the CPU |
| irq | output | 1 | Interrupt request |

## Verification
Directed strobes check the exact capture latency, irq falling while the strobe is held low with the buffer full, and an overrun. Together they separate correct latching from pass-through behaviour and from edge detection on the wrong polarity. A random mix of strobes with random bytes, data reads, bit set/reset writes to every index, command-form writes and address-0 writes runs against a bench model of the control register and the flags. This mix separates correct bit selection and value handling from neighbouring-bit corruption, and it shows whether ignored writes truly leave state alone. The status image is checked with random gpio_in values, which catches misplaced status fields.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int unsigned CTL_W = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned GPIO_W = 2;
  localparam int unsigned FULL_POS = 5;
  localparam int unsigned IRQ_POS = 3;

  typedef enum logic {
    SIP_DATA = 1'b0,
    SIP_CTRL = 1'b1
  } sip_addr_e;
endpackage

// File: rtl/sip_stb_sync.sv
module sip_stb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_n,
  output logic level,
  output logic level_nxt,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], stb_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level     = chain_q[STAGES-1];
  assign level_nxt = chain_q[STAGES-2];
  assign rise      = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sip_in_latch.sv
module sip_in_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              take,
  input  logic              ie_nxt,
  input  logic              level_nxt,
  input  logic [DATA_W-1:0] pins,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              irq_q
);
  logic full_n;

  always_comb begin
    full_n = full_q;
    if (take) full_n = 1'b0;
    if (rise) full_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (rise) data_q <= pins;
      full_q <= full_n;
      irq_q  <= full_n & ie_nxt & level_nxt;
    end
  end
endmodule

// File: rtl/sip_ctl_port.sv
module sip_ctl_port
  import sip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CTL_W-1:0] ctl_n
);
  logic [IDX_W-1:0] sel;
  assign sel = wdata[IDX_W:1];

  always_comb begin
    ctl_n = ctl_q;
    if (wr_en && !wdata[CTL_W-1]) begin
      for (int i = 0; i < CTL_W; i++) begin
        if (sel == IDX_W'(i)) ctl_n[i] = wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_n;
  end
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IE_BIT      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_addr,
  input  logic [CTL_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_stb_n,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_out,
  output logic              buf_full,
  output logic              irq
);
  localparam int unsigned GPIO_LSB = CTL_W - GPIO_W;

  logic              stb_level, stb_level_nxt, stb_rise;
  logic              rd_take, ctl_wr;
  logic [DATA_W-1:0] data_q;
  logic [CTL_W-1:0]  ctl_q, ctl_n, status;

  assign rd_take = cpu_rd && (cpu_addr == SIP_DATA);
  assign ctl_wr  = cpu_wr && (cpu_addr == SIP_CTRL);

  sip_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .stb_n(pin_stb_n),
    .level(stb_level), .level_nxt(stb_level_nxt), .rise(stb_rise)
  );

  sip_ctl_port u_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_wr), .wdata(cpu_wdata),
    .ctl_q(ctl_q), .ctl_n(ctl_n)
  );

  sip_in_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .rise(stb_rise), .take(rd_take),
    .ie_nxt(ctl_n[IE_BIT]), .level_nxt(stb_level_nxt), .pins(pin_data),
    .data_q(data_q), .full_q(buf_full), .irq_q(irq)
  );

  always_comb begin
    status                         = ctl_q;
    status[CTL_W-1:GPIO_LSB]       = gpio_in;
    status[FULL_POS]               = buf_full;
    status[IRQ_POS]                = irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      gpio_out  <= '0;
    end else begin
      gpio_out <= ctl_n[CTL_W-1:GPIO_LSB];
      if (cpu_rd) begin
        if (cpu_addr == SIP_DATA) cpu_rdata <= data_q;
        else                      cpu_rdata <= DATA_W'(status);
      end
    end
  end
endmodule

// File: rtl/strobed_input_port_sva.sv
module strobed_input_port_sva #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rise,
  input logic              level,
  input logic              take,
  input logic              cpu_wr,
  input logic              cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic [DATA_W-1:0] data_q,
  input logic [1:0]        gpio_out,
  input logic              buf_full,
  input logic              irq
);
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst) irq |-> buf_full); // R4
  AST_IRQ_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst) irq |-> level); // R4
  AST_RISE_SETS_FULL: assert property (@(posedge clk) disable iff (rst) rise |=> buf_full); // R2
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst) !rise |=> $stable(data_q)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (buf_full && !take) |=> buf_full); // R3
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst) (take && !rise) |=> (!buf_full && !irq)); // R5
  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (rst) (rise && buf_full) |=> buf_full); // R8
  AST_GPIO_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr && !cpu_wdata[7]) |=> $stable(gpio_out)); // R9
endmodule

bind strobed_input_port strobed_input_port_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst(rst), .rise(stb_rise), .level(stb_level), .take(rd_take),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .data_q(data_q),
  .gpio_out(gpio_out), .buf_full(buf_full), .irq(irq)
);

// File: tb/strobed_input_port_tb.sv
`timescale 1ns/1ps
module strobed_input_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, pin_data = '0;
  logic       pin_stb_n = 1'b1;
  logic [1:0] gpio_in = '0, gpio_out;
  logic       buf_full, irq;

  int checks = 0, failures = 0;
  logic [7:0] m_ctl = '0, m_data = '0;
  logic       m_full = 1'b0;

  always #5 clk = ~clk;

  strobed_input_port u_dut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_data(pin_data),
    .pin_stb_n(pin_stb_n), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .buf_full(buf_full), .irq(irq)
  );

  function automatic logic exp_irq();
    return m_full & m_ctl[4];
  endfunction

  function automatic logic [7:0] exp_status();
    return {gpio_in, m_full, m_ctl[4], exp_irq(), m_ctl[2:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    chk(req, {4'd0, buf_full, irq, gpio_out}, {4'd0, m_full, exp_irq(), m_ctl[7:6]});
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk); pin_data = d; pin_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    pin_stb_n = 1'b1;
    repeat (4) @(negedge clk);
    m_data = d; m_full = 1'b1;
  endtask

  task automatic cpu_read(input logic a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] w);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = w;
    @(negedge clk); cpu_wr = 1'b0;
    if (a && !w[7]) m_ctl[w[3:1]] = w[0];
  endtask

  task automatic read_data_check(input string req);
    logic [7:0] d;
    cpu_read(1'b0, d);
    chk(req, d, m_data);
    m_full = 1'b0;
    check_pins(req);
  endtask

  task automatic read_status_check(input string req);
    logic [7:0] d;
    cpu_read(1'b1, d);
    chk(req, d, exp_status());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check_pins("R1");
    chk("R1 rdata", cpu_rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    read_status_check("R1 status");

    // R2 exact latency and latching
    @(negedge clk); pin_data = 8'hA5; pin_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    pin_stb_n = 1'b1;
    pin_data = 8'hA5;
    repeat (2) @(negedge clk);
    chk("R2 not yet full", {7'd0, buf_full}, 8'h00);
    @(negedge clk);
    chk("R2 full after third edge", {7'd0, buf_full}, 8'h01);
    pin_data = 8'h3C;
    repeat (3) @(negedge clk);
    m_data = 8'hA5; m_full = 1'b1;
    check_pins("R3 held full");
    read_data_check("R5 latched byte, not pins");

    // R6 enable interrupt, R4 irq
    cpu_write(1'b1, 8'h09);
    read_status_check("R6 ie set");
    strobe(8'h5A);
    check_pins("R4 irq with ie");
    @(negedge clk); pin_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 irq drops while strobe low", {6'd0, buf_full, irq}, 8'h02);
    pin_data = 8'hC3; pin_stb_n = 1'b1;
    repeat (4) @(negedge clk);
    m_data = 8'hC3;
    check_pins("R8 overrun keeps full");
    read_data_check("R8 overrun byte");

    // R9 ignored writes
    strobe(8'h11);
    cpu_write(1'b1, 8'hFF);
    cpu_write(1'b0, 8'h00);
    check_pins("R9 ignored writes");
    read_status_check("R9 status after ignored writes");
    read_data_check("R5 read clears irq");

    // R7 gpio
    cpu_write(1'b1, 8'h0F);
    cpu_write(1'b1, 8'h0D);
    check_pins("R7 gpio out");
    gpio_in = 2'b10;
    read_status_check("R7 gpio in");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom % 6;
      gpio_in = 2'($urandom);
      case (op)
        0: begin strobe(8'($urandom)); check_pins("R2 random strobe"); end
        1: if (m_full) read_data_check("R5 random read");
        2: begin cpu_write(1'b1, {4'd0, 4'($urandom)}); check_pins("R6 random bit set/reset"); end
        3: begin cpu_write(1'b1, {1'b1, 7'($urandom)}); check_pins("R9 random command write"); end
        4: begin cpu_write(1'b0, 8'($urandom)); check_pins("R9 random data write"); end
        default: read_status_check("R10 random status");
      endcase
    end
    read_status_check("R10 final status");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule